// File: doc/BRIEF.md
# RF Gate Timing Generator

This block produces the linac RF gates and the high-voltage gate for each machine cycle. A cycle begins with a cycle-start strobe. Time inside the cycle is counted in ticks from a separate tick strobe. Every gate is anchored on its trailing edge at a programmed end-injection tick. Widening a gate therefore moves its leading edge earlier by the same number of ticks, and narrowing it moves the leading edge later.

Gate 0 is the low-level RF reference. Beam is allowed only after a programmed lead inside that gate, so the block also reports the widest beam pulse the gate can hold. The high-voltage gate opens a second programmed lead ahead of gate 0 and also closes at end-injection. A rate select picks one of a fixed set of repetition rates, and gates open only on the cycles that rate selects. When a leading edge would fall before cycle start, it is clamped to tick 0 and a per-gate flag is raised.

Top module: `rf_gate_gen`

## Requirements
- R1: Every gate output is low whenever the tick count of the current cycle is at or past `end_inj_i`.
- R2: For an enabled cycle, RF gate g is high exactly for tick counts from `end_inj_i - width_g` up to `end_inj_i - 1`, where width_g is bits [g*TW +: TW] of `rf_width_i`.
- R3: `beam_max_o` equals gate-0 width minus `llrf_lead_i`, or 0 when the lead exceeds the width.
- R4: The high-voltage gate is high from tick `end_inj_i - width_0 - hv_lead_i` up to `end_inj_i - 1`.
- R5: When a gate's start would be negative, its start is tick 0 and its `clamp_o` bit is set (bit g for RF gate g, bit N_GATE for the high-voltage gate); otherwise the bit is clear.
- R6: Cycle starts are numbered 0 to 59 and wrap, with 0 as the first one after reset. Rate select codes 0 to 5 mean 1, 2, 5, 10, 20 and 30 Hz. Cycle k is enabled when k mod (60/rate) is 0. `cycle_en_o` shows the decision for the current cycle.
- R7: Rate select codes 6 (60 Hz) and 7 are refused. Cycles started under them are never enabled, and no gate opens.
- R8: After reset and before the first cycle start, all gates, `cycle_en_o` and the tick count stay at zero, even while ticks arrive.
- R9: The rate select is sampled only at cycle start. Changing it in mid-cycle does not change the current cycle's enable.
- R10: A cycle start restarts the tick count at 0, and it takes priority over a tick in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | Cycle-start strobe, one clock |
| tick_i | input | 1 | Time-base tick strobe |
| rate_sel_i | input | 3 | Repetition-rate code |
| end_inj_i | input | TW | End-injection tick |
| rf_width_i | input | N_GATE*TW | Packed RF gate widths in ticks, gate 0 is low-level RF |
| llrf_lead_i | input | TW | Lead of gate 0 ahead of beam-on |
| hv_lead_i | input | TW | Lead of the high-voltage gate ahead of gate 0 |
| rf_gate_o | output | N_GATE | RF gates |
| hv_gate_o | output | 1 | High-voltage gate |
| beam_max_o | output | TW | Maximum beam pulse width in ticks |
| clamp_o | output | N_GATE+1 | Start clamped flags |
| cycle_en_o | output | 1 | Current cycle selected by the rate |

## Verification
The bench sweeps end-injection ticks, including 0, across widths below, equal to and above end-injection, and across several leads. An off-by-one comparison would show up as a gate one tick too long or a gate still high at end-injection. Subtracting without a clamp would wrap and open a gate late or never. All eight rate codes are run over more than two full 60-cycle wraps, so a wrong divisor, a counter that wraps at 59 or 61, or an accepted 60 Hz code would enable the wrong cycles. Mid-cycle rate changes and mid-cycle restarts catch a rate that is read continuously and a tick count that keeps running across a new cycle start.

// File: rtl/rf_gate_pkg.sv
package rf_gate_pkg;
  localparam int unsigned CYC_PER_SUPER = 60;
  localparam int unsigned CW = $clog2(CYC_PER_SUPER);

  typedef enum logic [2:0] {
    RATE_1HZ  = 3'd0,
    RATE_2HZ  = 3'd1,
    RATE_5HZ  = 3'd2,
    RATE_10HZ = 3'd3,
    RATE_20HZ = 3'd4,
    RATE_30HZ = 3'd5,
    RATE_60HZ = 3'd6,
    RATE_OFF  = 3'd7
  } rate_e;

  // cycles between enabled cycles; 0 marks a refused rate
  function automatic logic [CW-1:0] rate_div(input logic [2:0] sel);
    case (rate_e'(sel))
      RATE_1HZ:  return CW'(60);
      RATE_2HZ:  return CW'(30);
      RATE_5HZ:  return CW'(12);
      RATE_10HZ: return CW'(6);
      RATE_20HZ: return CW'(3);
      RATE_30HZ: return CW'(2);
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/rf_gate_rate.sv
module rf_gate_rate
  import rf_gate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cyc_start_i,
  input  logic [2:0] rate_sel_i,
  output logic       cycle_en_o
);
  logic [CW-1:0] cyc_q;
  logic [CW-1:0] div;
  logic          hit;
  logic          en_q;

  assign div = rate_div(rate_sel_i);
  assign hit = (div != '0) && ((cyc_q % div) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      en_q  <= 1'b0;
    end else if (cyc_start_i) begin
      en_q  <= hit;
      cyc_q <= (cyc_q == CW'(CYC_PER_SUPER - 1)) ? '0 : cyc_q + 1'b1;
    end
  end

  assign cycle_en_o = en_q;
endmodule

// File: rtl/rf_gate_timebase.sv
module rf_gate_timebase #(
  parameter int unsigned TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cyc_start_i,
  input  logic          tick_i,
  output logic [TW-1:0] cnt_o,
  output logic          run_o
);
  logic [TW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cyc_start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (tick_i && run_q && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/rf_gate_window.sv
module rf_gate_window #(
  parameter int unsigned TW = 12,
  parameter int unsigned WW = TW
) (
  input  logic [WW-1:0] width_i,
  input  logic [TW-1:0] end_i,
  input  logic [TW-1:0] cnt_i,
  input  logic          en_i,
  output logic          gate_o,
  output logic          clamp_o
);
  logic [WW-1:0] end_x;
  logic [WW-1:0] start_x;
  logic [TW-1:0] start;

  assign end_x   = WW'(end_i);
  assign clamp_o = width_i > end_x;
  assign start_x = clamp_o ? '0 : end_x - width_i;
  // start never exceeds end_i, so truncation is lossless
  assign start   = start_x[TW-1:0];
  assign gate_o  = en_i && (cnt_i >= start) && (cnt_i < end_i);
endmodule

// File: rtl/rf_gate_gen.sv
module rf_gate_gen #(
  parameter int unsigned TW     = 12,
  parameter int unsigned N_GATE = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cyc_start_i,
  input  logic                 tick_i,
  input  logic [2:0]           rate_sel_i,
  input  logic [TW-1:0]        end_inj_i,
  input  logic [N_GATE*TW-1:0] rf_width_i,
  input  logic [TW-1:0]        llrf_lead_i,
  input  logic [TW-1:0]        hv_lead_i,
  output logic [N_GATE-1:0]    rf_gate_o,
  output logic                 hv_gate_o,
  output logic [TW-1:0]        beam_max_o,
  output logic [N_GATE:0]      clamp_o,
  output logic                 cycle_en_o
);
  localparam int unsigned HW = TW + 1;

  logic [TW-1:0] cnt;
  logic          run;
  logic          cyc_en;
  logic          gate_en;
  logic [TW-1:0] llrf_w;
  logic [HW-1:0] hv_w;

  rf_gate_timebase #(.TW(TW)) u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_start_i(cyc_start_i),
    .tick_i     (tick_i),
    .cnt_o      (cnt),
    .run_o      (run)
  );

  rf_gate_rate u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_start_i(cyc_start_i),
    .rate_sel_i (rate_sel_i),
    .cycle_en_o (cyc_en)
  );

  assign gate_en    = run && cyc_en;
  assign cycle_en_o = cyc_en;

  for (genvar g = 0; g < N_GATE; g++) begin : g_rf
    rf_gate_window #(.TW(TW), .WW(TW)) u_win (
      .width_i(rf_width_i[g*TW +: TW]),
      .end_i  (end_inj_i),
      .cnt_i  (cnt),
      .en_i   (gate_en),
      .gate_o (rf_gate_o[g]),
      .clamp_o(clamp_o[g])
    );
  end

  assign llrf_w = rf_width_i[TW-1:0];
  // HV gate spans gate 0 plus its own lead; one extra bit avoids wrap
  assign hv_w   = {1'b0, llrf_w} + {1'b0, hv_lead_i};

  rf_gate_window #(.TW(TW), .WW(HW)) u_hv (
    .width_i(hv_w),
    .end_i  (end_inj_i),
    .cnt_i  (cnt),
    .en_i   (gate_en),
    .gate_o (hv_gate_o),
    .clamp_o(clamp_o[N_GATE])
  );

  assign beam_max_o = (llrf_w > llrf_lead_i) ? llrf_w - llrf_lead_i : '0;
endmodule

// File: rtl/rf_gate_gen_chk.sv
module rf_gate_gen_chk #(
  parameter int unsigned TW     = 12,
  parameter int unsigned N_GATE = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cyc_start_i,
  input logic                 tick_i,
  input logic [2:0]           rate_sel_i,
  input logic [TW-1:0]        end_inj_i,
  input logic [N_GATE*TW-1:0] rf_width_i,
  input logic [TW-1:0]        llrf_lead_i,
  input logic [TW-1:0]        hv_lead_i,
  input logic [N_GATE-1:0]    rf_gate_o,
  input logic                 hv_gate_o,
  input logic [TW-1:0]        beam_max_o,
  input logic [N_GATE:0]      clamp_o,
  input logic                 cycle_en_o
);
  logic [TW-1:0] tcnt;
  logic          seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt <= '0;
      seen <= 1'b0;
    end else if (cyc_start_i) begin
      tcnt <= '0;
      seen <= 1'b1;
    end else if (tick_i && seen && (tcnt != '1)) begin
      tcnt <= tcnt + 1'b1;
    end
  end

  // R1
  end_inj_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && tcnt >= end_inj_i) |-> (rf_gate_o == '0 && !hv_gate_o));

  // R3
  beam_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beam_max_o <= rf_width_i[TW-1:0]) && (beam_max_o >= rf_width_i[TW-1:0] - llrf_lead_i
      || llrf_lead_i > rf_width_i[TW-1:0]));

  // R4
  hv_covers_llrf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_gate_o[0] |-> hv_gate_o);

  // R5
  hv_clamp_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_o[N_GATE] && seen && cycle_en_o && tcnt < end_inj_i) |-> hv_gate_o);

  // R7
  refused_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && rate_sel_i >= 3'd6) |=> !cycle_en_o);

  // R7
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_en_o |-> (rf_gate_o == '0 && !hv_gate_o));

  // R8
  pre_start_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen |-> (rf_gate_o == '0 && !hv_gate_o && !cycle_en_o));

  for (genvar g = 0; g < N_GATE; g++) begin : g_chk
    logic [TW:0] wg;
    assign wg = {1'b0, rf_width_i[g*TW +: TW]};
    // R2
    early_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && (({1'b0, tcnt} + wg) < {1'b0, end_inj_i})) |-> !rf_gate_o[g]);
    // R5
    clamp_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clamp_o[g] && seen && cycle_en_o && tcnt < end_inj_i) |-> rf_gate_o[g]);
  end
endmodule

bind rf_gate_gen rf_gate_gen_chk #(.TW(TW), .N_GATE(N_GATE)) u_chk (.*);

// File: tb/sim_rf_gate_gen.sv
module sim_rf_gate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int NG = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cyc = 1'b0;
  logic            tick = 1'b0;
  logic [2:0]      rate = 3'd0;
  logic [TW-1:0]   end_inj = '0;
  logic [NG*TW-1:0] widths = '0;
  logic [TW-1:0]   llrf_lead = '0;
  logic [TW-1:0]   hv_lead = '0;
  logic [NG-1:0]   rf_gate;
  logic            hv_gate;
  logic [TW-1:0]   beam_max;
  logic [NG:0]     clamp;
  logic            cyc_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rf_gate_gen #(.TW(TW), .N_GATE(NG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cyc_start_i(cyc), .tick_i(tick),
    .rate_sel_i(rate), .end_inj_i(end_inj), .rf_width_i(widths),
    .llrf_lead_i(llrf_lead), .hv_lead_i(hv_lead), .rf_gate_o(rf_gate),
    .hv_gate_o(hv_gate), .beam_max_o(beam_max), .clamp_o(clamp),
    .cycle_en_o(cyc_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cyc = 1'b0; tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic pulse_start(bit with_tick = 0);
    @(negedge clk);
    cyc = 1'b1; tick = with_tick;
    @(negedge clk);
    cyc = 1'b0; tick = 1'b0;
    #1;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    #1;
  endtask

  function automatic int start_of(int w, int e);
    return (w > e) ? 0 : e - w;
  endfunction

  function automatic int div_of(int sel);
    case (sel)
      0: return 60;
      1: return 30;
      2: return 12;
      3: return 6;
      4: return 3;
      5: return 2;
      default: return 0;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ends_a[3] = '{0, 5, 20};
    int w0_a[5] = '{0, 3, 5, 12, 25};
    int ll_a[3] = '{0, 4, 9};
    int hv_a[3] = '{0, 2, 7};

    // R8: reset state and ticks before any cycle start
    end_inj = 8'd6; widths = {8'd3, 8'd4}; rate = 3'd0;
    do_reset();
    chk("R8", "gates after reset", int'({rf_gate, hv_gate}), 0);
    chk("R8", "cycle_en after reset", int'(cyc_en), 0);
    for (int i = 0; i < 8; i++) begin
      pulse_tick();
      chk("R8", "gates before first start", int'({rf_gate, hv_gate}), 0);
    end

    // R1 R2 R3 R4 R5: window sweep
    foreach (ends_a[ie]) foreach (w0_a[iw]) foreach (ll_a[il]) foreach (hv_a[ih]) begin
      int e, w0, w1, s0, s1, wh, sh, bm;
      e = ends_a[ie]; w0 = w0_a[iw]; w1 = (w0 * 3 + 1) % 30;
      end_inj = TW'(e); widths = {TW'(w1), TW'(w0)};
      llrf_lead = TW'(ll_a[il]); hv_lead = TW'(hv_a[ih]); rate = 3'd0;
      do_reset();
      pulse_start();
      s0 = start_of(w0, e); s1 = start_of(w1, e);
      wh = w0 + hv_a[ih]; sh = start_of(wh, e);
      bm = (w0 > ll_a[il]) ? w0 - ll_a[il] : 0;
      chk("R3", "beam_max", int'(beam_max), bm);
      chk("R5", "clamp gate0", int'(clamp[0]), int'(w0 > e));
      chk("R5", "clamp gate1", int'(clamp[1]), int'(w1 > e));
      chk("R5", "clamp hv", int'(clamp[NG]), int'(wh > e));
      for (int t = 0; t <= e + 2; t++) begin
        if (t >= e) chk("R1", "all gates at/after end", int'({rf_gate, hv_gate}), 0);
        chk("R2", "gate0", int'(rf_gate[0]), int'(t >= s0 && t < e));
        chk("R2", "gate1", int'(rf_gate[1]), int'(t >= s1 && t < e));
        chk("R4", "hv gate", int'(hv_gate), int'(t >= sh && t < e));
        pulse_tick();
      end
    end

    // R6 R7: rate selection across more than two supercycle wraps
    end_inj = 8'd3; widths = {8'd2, 8'd2}; llrf_lead = '0; hv_lead = '0;
    for (int sel = 0; sel < 8; sel++) begin
      rate = 3'(sel);
      do_reset();
      for (int c = 0; c < 130; c++) begin
        int d;
        bit exp_en;
        d = div_of(sel);
        exp_en = (d != 0) && (((c % 60) % d) == 0);
        pulse_start();
        if (sel >= 6) chk("R7", "refused rate cycle_en", int'(cyc_en), 0);
        else          chk("R6", "cycle_en", int'(cyc_en), int'(exp_en));
        pulse_tick();
        chk(sel >= 6 ? "R7" : "R6", "gate0 on enable", int'(rf_gate[0]), int'(exp_en));
      end
    end

    // R9: mid-cycle rate change ignored until next start
    end_inj = 8'd10; widths = {8'd4, 8'd4};
    rate = 3'd3;
    do_reset();
    pulse_start();
    chk("R9", "cycle0 enabled", int'(cyc_en), 1);
    rate = 3'd6;
    for (int i = 0; i < 7; i++) pulse_tick();
    chk("R9", "enable kept after mid change", int'(cyc_en), 1);
    chk("R9", "gate0 still on", int'(rf_gate[0]), 1);
    pulse_start();
    chk("R9", "new rate at next start", int'(cyc_en), 0);

    // R10: restart of tick count, start wins over tick
    rate = 3'd5;
    do_reset();
    pulse_start();
    for (int i = 0; i < 8; i++) pulse_tick();
    chk("R10", "gate0 at tick 8", int'(rf_gate[0]), 1);
    pulse_start();
    pulse_start(1);
    chk("R10", "gate0 at restart", int'(rf_gate[0]), 0);
    for (int i = 0; i < 5; i++) pulse_tick();
    chk("R10", "gate0 at tick 5", int'(rf_gate[0]), 0);
    pulse_tick();
    chk("R10", "gate0 at tick 6", int'(rf_gate[0]), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule